// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Aggregator

This block collects up to 256 level-sensitive interrupt sources, organised as 32-bit words, and drives one interrupt line per CPU. All CPUs see the same synchronised source status. Each CPU owns a private mask and selects its own register window through a CPU-select index on a simple 32-bit register bus. A CPU drives its interrupt line whenever any source that its mask leaves enabled is active.

Software changes a mask only through atomic bit operations. One register sets the mask bits chosen by the 1 bits of the write data. A second register clears the bits chosen in the same way. No read-modify-write sequence is needed. The registers are grouped by function across all words, so the address map grows with the word count parameter.

Top module: `irq_agg_top`

## Requirements
- R1: After a synchronous active-low reset, every mask bit of every CPU is 1, every interrupt output is 0 and every STATUS word reads 0.
- R2: A register's byte offset is (bank × N_WORDS + word) × 4, with bank 0 STATUS, 1 MASK_STATUS, 2 MASK_SET and 3 MASK_CLEAR. Address bits [1:0] are ignored. Read data is combinational from the address and the CPU index.
- R3: STATUS word w returns source inputs [32w+31:32w] two clock edges after they change, through a two-flop synchronizer. All CPU windows return the same value.
- R4: A write to MASK_SET word w sets each mask bit of the selected CPU where the data bit is 1. Bits written as 0 keep their value.
- R5: A write to MASK_CLEAR word w clears each mask bit of the selected CPU where the data bit is 1. Bits written as 0 keep their value.
- R6: MASK_STATUS reads return the selected CPU's current mask. MASK_SET and MASK_CLEAR read as 0.
- R7: Writes to STATUS or MASK_STATUS change neither a mask nor the status.
- R8: Interrupt output c is registered. One edge after a change, it equals the OR over all words of STATUS AND NOT mask of CPU c. A mask of 1 disables its source.
- R9: A mask write changes only the mask of the CPU named by the CPU index. The other CPUs' masks and interrupt outputs are unaffected.
- R10: A CPU index of N_CPUS or above, or a byte offset of 16 × N_WORDS or above, reads 0 and a write to it has no effect.
- R11: Sources are level-sensitive. STATUS holds a source while its input stays asserted, reading does not clear it, and it drops once the input is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32*N_WORDS | Level interrupt sources, word w at bits [32w+31:32w] |
| cpu_sel_i | input | CPU_W | CPU window selected for the access |
| addr_i | input | ADDR_W | Byte address of the register |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Combinational read data |
| irq_o | output | N_CPUS | Per-CPU interrupt outputs |

## Verification
The assertions check several properties on every cycle. Set and clear writes must reach exactly the addressed mask word and change nothing else. Status must trail the sources by exactly two edges. An interrupt line must never be raised while its mask is all ones or while the status was empty. Only one CPU's mask may be written per cycle. The scenarios are needed to show the rest: the address map and its out-of-range region, the zero reads of the action registers, the one-cycle delay of the interrupt output after a mask write, and the independence of the two CPU windows over the same pending source.

// File: rtl/irq_agg_pkg.sv
// Shared constants and the register bank encoding of the interrupt aggregator.
// Assumes the bank order is fixed: status, mask readback, set, clear.
package irq_agg_pkg;
    localparam int SRC_PER_WORD = 32;
    localparam int BANK_COUNT   = 4;

    typedef enum logic [1:0] {
        BANK_STATUS = 2'd0,
        BANK_MASK   = 2'd1,
        BANK_SET    = 2'd2,
        BANK_CLR    = 2'd3
    } bank_e;
endpackage

// File: rtl/irq_agg_sync.sv
// Two-flop synchronizer for the level interrupt sources.
// Assumes the sources are quasi-static levels, so per-bit synchronisation is enough.
module irq_agg_sync #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] src_i,
    output logic [WIDTH-1:0] status_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stat_q;

    // Two register stages between the raw inputs and the visible status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stat_q <= '0;
        end else begin
            meta_q <= src_i;
            stat_q <= meta_q;
        end
    end

    assign status_o = stat_q;

    // R3: status is the source value from exactly two edges earlier.
    assert_sync_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (status_o == $past(src_i, 2)));
endmodule

// File: rtl/irq_agg_mask.sv
// Mask storage and registered interrupt output for one CPU.
// Assumes at most one of set_we_i / clr_we_i is high in a cycle.
module irq_agg_mask
    import irq_agg_pkg::*;
#(
    parameter int N_WORDS = 2,
    localparam int WSEL_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
    localparam int FLAT_W = N_WORDS * SRC_PER_WORD
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    set_we_i,
    input  logic                    clr_we_i,
    input  logic [WSEL_W-1:0]       word_sel_i,
    input  logic [SRC_PER_WORD-1:0] wdata_i,
    input  logic [FLAT_W-1:0]       status_i,
    output logic [FLAT_W-1:0]       mask_o,
    output logic                    irq_o
);
    logic [N_WORDS-1:0][SRC_PER_WORD-1:0] mask_q;
    logic                                 pend_any;
    logic                                 irq_q;

    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        logic hit;
        assign hit = (word_sel_i == WSEL_W'(w));

        // Apply set or clear bit operations to this mask word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[w] <= '1;
            end else if (set_we_i && hit) begin
                mask_q[w] <= mask_q[w] | wdata_i;
            end else if (clr_we_i && hit) begin
                mask_q[w] <= mask_q[w] & ~wdata_i;
            end
        end

        assign mask_o[w*SRC_PER_WORD +: SRC_PER_WORD] = mask_q[w];

        // R4: after a set write, every written 1 bit reads back as masked.
        assert_set_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(set_we_i) && ($past(word_sel_i) == WSEL_W'(w)))
            |-> ((mask_q[w] & $past(wdata_i)) == $past(wdata_i)));

        // R5: after a clear write, every written 1 bit reads back as enabled.
        assert_clr_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(clr_we_i) && ($past(word_sel_i) == WSEL_W'(w)))
            |-> ((mask_q[w] & $past(wdata_i)) == '0));

        // R7: a word not targeted by a set or clear write keeps its value.
        assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !(($past(set_we_i) || $past(clr_we_i))
                               && ($past(word_sel_i) == WSEL_W'(w))))
            |-> $stable(mask_q[w]));
    end

    // Any enabled active source across all words.
    always_comb begin
        pend_any = |(status_i & ~mask_o);
    end

    // Register the interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= pend_any;
    end

    assign irq_o = irq_q;

    // R8: a raised line needs a non-empty status on the previous cycle.
    assert_irq_needs_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(status_i != '0));

    // R8: a fully masked CPU never sees its line raised one cycle later.
    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(&mask_o) |-> !irq_o);
endmodule

// File: rtl/irq_agg_regif.sv
// Register decode: splits the byte address into bank and word, produces
// per-CPU set/clear strobes and the combinational read data.
// Assumes word-aligned access; the low two address bits are ignored.
module irq_agg_regif
    import irq_agg_pkg::*;
#(
    parameter int N_WORDS = 2,
    parameter int N_CPUS  = 2,
    parameter int ADDR_W  = 8,
    localparam int WSEL_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
    localparam int CPU_W   = (N_CPUS > 1) ? $clog2(N_CPUS) : 1,
    localparam int FLAT_W  = N_WORDS * SRC_PER_WORD,
    localparam int REG_CNT = BANK_COUNT * N_WORDS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CPU_W-1:0]         cpu_sel_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic                     wr_en_i,
    input  logic [FLAT_W-1:0]        status_i,
    input  logic [N_CPUS*FLAT_W-1:0] mask_all_i,
    output logic [N_CPUS-1:0]        set_we_o,
    output logic [N_CPUS-1:0]        clr_we_o,
    output logic [WSEL_W-1:0]        word_sel_o,
    output logic [SRC_PER_WORD-1:0]  rd_data_o
);
    logic [ADDR_W-3:0]       reg_idx;
    logic                    in_range;
    logic                    cpu_ok;
    bank_e                   bank;
    logic [WSEL_W-1:0]       word;
    logic [SRC_PER_WORD-1:0] stat_word;
    logic [SRC_PER_WORD-1:0] mask_word;

    assign reg_idx = addr_i[ADDR_W-1:2];

    // Split the register index into bank and word, and flag legal accesses.
    always_comb begin
        in_range = int'(reg_idx) < REG_CNT;
        cpu_ok   = int'(cpu_sel_i) < N_CPUS;
        if (in_range) begin
            bank = bank_e'(2'(int'(reg_idx) / N_WORDS));
            word = WSEL_W'(int'(reg_idx) % N_WORDS);
        end else begin
            bank = BANK_STATUS;
            word = '0;
        end
    end

    assign word_sel_o = word;

    // Raise a strobe only for the selected CPU and an action bank.
    always_comb begin
        set_we_o = '0;
        clr_we_o = '0;
        if (wr_en_i && in_range && cpu_ok) begin
            for (int c = 0; c < N_CPUS; c++) begin
                if (c == int'(cpu_sel_i)) begin
                    set_we_o[c] = (bank == BANK_SET);
                    clr_we_o[c] = (bank == BANK_CLR);
                end
            end
        end
    end

    // Pick the addressed status word and the selected CPU's mask word.
    always_comb begin
        stat_word = '0;
        mask_word = '0;
        for (int w = 0; w < N_WORDS; w++) begin
            if (w == int'(word)) begin
                stat_word = status_i[w*SRC_PER_WORD +: SRC_PER_WORD];
                for (int c = 0; c < N_CPUS; c++) begin
                    if (c == int'(cpu_sel_i)) begin
                        mask_word = mask_all_i[(c*N_WORDS + w)*SRC_PER_WORD +: SRC_PER_WORD];
                    end
                end
            end
        end
    end

    // Read multiplexer; action banks and illegal accesses return zero.
    always_comb begin
        rd_data_o = '0;
        if (in_range && cpu_ok) begin
            case (bank)
                BANK_STATUS: rd_data_o = stat_word;
                BANK_MASK:   rd_data_o = mask_word;
                default:     rd_data_o = '0;
            endcase
        end
    end

    // R10: writes beyond the register map raise no strobe.
    assert_oob_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (int'(addr_i) >= 16 * N_WORDS)) |-> ((set_we_o == '0) && (clr_we_o == '0)));

    // R10: reads beyond the register map return zero.
    assert_oob_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr_i) >= 16 * N_WORDS) |-> (rd_data_o == '0));

    // R6: the action registers always read as zero.
    assert_action_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(addr_i) >= 8 * N_WORDS) && (int'(addr_i) < 16 * N_WORDS)) |-> (rd_data_o == '0));
endmodule

// File: rtl/irq_agg_top.sv
// Multi-CPU level interrupt aggregator top: synchronizer, register decode,
// and one mask/interrupt slice per CPU over a shared status.
// Assumes one register access per cycle, issued on behalf of cpu_sel_i.
module irq_agg_top
    import irq_agg_pkg::*;
#(
    parameter int N_WORDS = 2,
    parameter int N_CPUS  = 2,
    parameter int ADDR_W  = 8,
    localparam int CPU_W  = (N_CPUS > 1) ? $clog2(N_CPUS) : 1,
    localparam int WSEL_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
    localparam int FLAT_W = N_WORDS * SRC_PER_WORD
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [FLAT_W-1:0]       src_i,
    input  logic [CPU_W-1:0]        cpu_sel_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    wr_en_i,
    input  logic [SRC_PER_WORD-1:0] wr_data_i,
    output logic [SRC_PER_WORD-1:0] rd_data_o,
    output logic [N_CPUS-1:0]       irq_o
);
    logic [FLAT_W-1:0]        status;
    logic [N_CPUS*FLAT_W-1:0] mask_all;
    logic [N_CPUS-1:0]        set_we;
    logic [N_CPUS-1:0]        clr_we;
    logic [WSEL_W-1:0]        word_sel;

    irq_agg_sync #(.WIDTH(FLAT_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_i),
        .status_o (status)
    );

    irq_agg_regif #(.N_WORDS(N_WORDS), .N_CPUS(N_CPUS), .ADDR_W(ADDR_W)) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_sel_i  (cpu_sel_i),
        .addr_i     (addr_i),
        .wr_en_i    (wr_en_i),
        .status_i   (status),
        .mask_all_i (mask_all),
        .set_we_o   (set_we),
        .clr_we_o   (clr_we),
        .word_sel_o (word_sel),
        .rd_data_o  (rd_data_o)
    );

    for (genvar c = 0; c < N_CPUS; c++) begin : g_cpu
        irq_agg_mask #(.N_WORDS(N_WORDS)) u_mask (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_we_i   (set_we[c]),
            .clr_we_i   (clr_we[c]),
            .word_sel_i (word_sel),
            .wdata_i    (wr_data_i),
            .status_i   (status),
            .mask_o     (mask_all[c*FLAT_W +: FLAT_W]),
            .irq_o      (irq_o[c])
        );
    end

    // R9: at most one CPU slice receives a mask write per cycle.
    assert_single_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_we | clr_we));
endmodule

// File: tb/irq_agg_top_tb.sv
// Directed bench for irq_agg_top with N_WORDS = 2 and N_CPUS = 2.
module irq_agg_top_tb;
    localparam int NW = 2;
    localparam int NC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NW*32-1:0] src = '0;
    logic [0:0]    cpu_sel = '0;
    logic [7:0]    addr = '0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic [NC-1:0] irq;

    int checks = 0;
    int errors = 0;

    irq_agg_top #(.N_WORDS(NW), .N_CPUS(NC), .ADDR_W(8)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src),
        .cpu_sel_i (cpu_sel),
        .addr_i    (addr),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_data_o (rd_data),
        .irq_o     (irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input int cpu, input int a, input logic [31:0] d);
        @(negedge clk);
        cpu_sel = 1'(cpu); addr = 8'(a); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int cpu, input int a, output logic [31:0] d);
        @(negedge clk);
        cpu_sel = 1'(cpu); addr = 8'(a); wr_en = 1'b0;
        #1 d = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int c = 0; c < NC; c++) begin
            rd(c, 8'h08, d); check("R1 mask w0", d, 32'hFFFF_FFFF);
            rd(c, 8'h0C, d); check("R1 mask w1", d, 32'hFFFF_FFFF);
            rd(c, 8'h04, d); check("R1 status w1", d, 32'h0);
        end
        check("R1 irq", 32'(irq), 32'h0);
    endtask

    task automatic t_status();
        logic [31:0] d;
        @(negedge clk);
        cpu_sel = 1'b0; addr = 8'h00;
        src = {32'hA5A5_0000, 32'h0000_0010};
        @(negedge clk); #1 check("R3 status after one edge", rd_data, 32'h0);
        @(negedge clk); #1 check("R3 status after two edges", rd_data, 32'h0000_0010);
        rd(1, 8'h04, d); check("R3 R2 status w1 via cpu1", d, 32'hA5A5_0000);
        rd(0, 8'h04, d); check("R3 status w1 via cpu0", d, 32'hA5A5_0000);
        @(negedge clk); #1 check("R8 fully masked irq low", 32'(irq), 32'h0);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(0, 8'h18, 32'h0000_0010);
        #1 check("R8 irq0 not yet raised", 32'(irq[0]), 32'h0);
        @(negedge clk); #1 check("R8 irq0 raised", 32'(irq[0]), 32'h1);
        check("R9 irq1 stays low", 32'(irq[1]), 32'h0);
        rd(0, 8'h08, d); check("R5 R2 mask w0 cpu0", d, 32'hFFFF_FFEF);
        rd(1, 8'h08, d); check("R9 mask w0 cpu1", d, 32'hFFFF_FFFF);
        rd(0, 8'h0C, d); check("R5 mask w1 cpu0 untouched", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_readzero();
        logic [31:0] d;
        rd(0, 8'h10, d); check("R6 set bank reads zero", d, 32'h0);
        rd(0, 8'h1C, d); check("R6 clear bank reads zero", d, 32'h0);
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        wr(0, 8'h08, 32'h0);
        wr(0, 8'h00, 32'hFFFF_FFFF);
        rd(0, 8'h08, d); check("R7 mask unchanged", d, 32'hFFFF_FFEF);
        rd(0, 8'h00, d); check("R7 status unchanged", d, 32'h0000_0010);
        check("R7 irq0 still high", 32'(irq[0]), 32'h1);
    endtask

    task automatic t_oob();
        logic [31:0] d;
        wr(0, 8'h20, 32'hFFFF_FFFF);
        wr(0, 8'h98, 32'hFFFF_FFFF);
        rd(0, 8'h08, d); check("R10 mask unchanged", d, 32'hFFFF_FFEF);
        @(negedge clk); #1 check("R10 irq0 still high", 32'(irq[0]), 32'h1);
        rd(0, 8'h20, d); check("R10 read beyond map", d, 32'h0);
        rd(1, 8'h3C, d); check("R10 read far beyond map", d, 32'h0);
    endtask

    task automatic t_set();
        logic [31:0] d;
        wr(0, 8'h10, 32'h0000_0010);
        #1 check("R8 irq0 holds one cycle", 32'(irq[0]), 32'h1);
        @(negedge clk); #1 check("R8 irq0 dropped", 32'(irq[0]), 32'h0);
        rd(0, 8'h08, d); check("R4 mask w0 restored", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(1, 8'h1C, 32'h0001_0000);
        @(negedge clk); #1 check("R9 irq1 raised from word1", 32'(irq[1]), 32'h1);
        check("R9 irq0 low", 32'(irq[0]), 32'h0);
        rd(1, 8'h0C, d); check("R5 mask w1 cpu1", d, 32'hFFFE_FFFF);
        rd(1, 8'h04, d); check("R11 first read", d, 32'hA5A5_0000);
        rd(1, 8'h04, d); check("R11 read does not clear", d, 32'hA5A5_0000);
        check("R11 irq1 held", 32'(irq[1]), 32'h1);
        @(negedge clk);
        cpu_sel = 1'b1; addr = 8'h04;
        src = '0;
        @(negedge clk);
        @(negedge clk); #1 check("R11 status drops", rd_data, 32'h0);
        check("R8 irq1 one more cycle", 32'(irq[1]), 32'h1);
        @(negedge clk); #1 check("R11 irq1 drops", 32'(irq[1]), 32'h0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_status();
        t_clear();
        t_readzero();
        t_ignored();
        t_oob();
        t_set();
        t_level();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule